// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Refresh

This block sits between a simple host request port and a 4096 x 1 dynamic memory whose array is organised as 64 rows of 64 bits. The host presents a single-bit read or write with a 12-bit address. The controller sends that address to the memory in two halves over one shared 6-bit bus. The row half goes first and is taken by the memory when the row strobe falls. The column half follows and is taken when the column strobe falls. Every strobe setup and pulse length is a whole number of clock cycles, worked out from a clock-frequency parameter and nanosecond timing parameters.

Dynamic cells leak, so the controller also issues one row refresh per refresh interval. All 64 rows are therefore covered inside a 4 ms deadline. A configuration input picks one of two refresh styles. In the first, the controller pulses the row strobe alone while driving a row pointer that it advances itself. In the second, the column strobe goes low ahead of the row strobe and the memory refreshes from its own internal pointer. A refresh that becomes due during an access waits until that access ends. The host sees a ready output and may only issue a request while ready is high.

Top module: `dram_mux_ctrl`

## Requirements
- R1: The row part of the address is `req_addr[11:6]` and the column part is `req_addr[5:0]`. Both go out on `dram_a`: the row is on the bus when `dram_ras_n` falls, and the column is on the bus when `dram_cas_n` falls. Data written to an address is read back from the same address.
- R2: A read lowers `dram_ras_n` before `dram_cas_n`. It captures `dram_q` only while both strobes are low. It then reports the bit on `rd_data` together with a single-cycle `rd_valid` pulse.
- R3: A write runs in this order, each step in a later cycle than the one before: row strobe low, `dram_we_n` low, column strobe low (the bit is replaced), row strobe high (the row is written back), column strobe high.
- R4: One refresh starts every REF_CYC = CLK_MHZ*62500/1000 clock cycles. A start may be pushed back by at most one access.
- R5: In row-only refresh (`cfg_cbr` = 0), `dram_cas_n` stays high while `dram_ras_n` pulses. The row on `dram_a` is an internal pointer that starts at 0 after reset and advances by one, modulo 64, after each refresh.
- R6: In column-first refresh (`cfg_cbr` = 1), `dram_cas_n` falls at least one cycle before `dram_ras_n`, and `dram_we_n` stays high.
- R7: A refresh that falls due during an access stays pending and starts after that access. No row goes longer than 64*REF_CYC cycles, plus at most one access, without a row-strobe cycle.
- R8: `ready` is low from the start of a refresh until the refresh has finished. While `ready` is high, all strobes are high.
- R9: During and right after reset, all strobes are high, `ready` is high and `rd_valid` is low.
- R10: The value of `cfg_cbr` at the start of a refresh decides which refresh style that refresh uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cbr | input | 1 | Refresh style: 0 = row-only, 1 = column-first |
| req_valid | input | 1 | Host request, taken when ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Bit address, row in [11:6], column in [5:0] |
| req_wdata | input | 1 | Bit to write |
| ready | output | 1 | Controller can take a request this cycle |
| rd_valid | output | 1 | One-cycle pulse marking read data |
| rd_data | output | 1 | Read bit |
| dram_a | output | 6 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_d | output | 1 | Data to memory |
| dram_q | input | 1 | Data from memory, high impedance unless driven |

## Verification
The bench aims at refreshes that fall due in the middle of back-to-back traffic. If the design dropped that pending refresh, a row would overrun its deadline. If it delayed the refresh too long, the interval check would fail. The bench follows the row-only refresh pointer one refresh at a time, so a pointer that skipped or failed to wrap would give the wrong row. In the write sequence, the order of the two rising strobes is checked. If the column strobe rose first, the memory model would not write the row back, and later reads would return stale data. Each refresh is also checked against the style selected at the time, and the bench confirms that `ready` is low for the whole refresh.

// File: rtl/dram_ctrl_pkg.sv
// Shared types and helpers for the multiplexed-address DRAM controller.
// Assumes all timing parameters are given in nanoseconds and a clock in MHz.
package dram_ctrl_pkg;

    // Sequencer states; each holds a fixed strobe pattern
    typedef enum logic [3:0] {
        S_IDLE,
        S_ROW,      // row on bus, strobes high
        S_RAS,      // row strobe low, row held
        S_COL,      // column on bus, write enable for writes
        S_CAS,      // both strobes low
        S_WRUP,     // write: row strobe up first (write-back)
        S_PRE,      // all strobes high, precharge
        S_RF_ROW,   // row-only refresh: pointer on bus
        S_RF_RAS,   // row-only refresh: row strobe low
        S_CBR_CAS,  // column-first refresh: column strobe low
        S_CBR_RAS   // column-first refresh: both low
    } seq_state_e;

    // Round a nanosecond figure up to whole clock cycles, minimum one
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 999) / 1000;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
// Refresh interval timer and row-only refresh pointer.
// Raises refresh_due once per REF_CYC cycles and holds it until the
// sequencer takes it; the row pointer advances on each row-only refresh.
module dram_refresh_timer #(
    parameter int unsigned REF_CYC = 625,
    parameter int unsigned ROW_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             adv_ptr,
    output logic             refresh_due,
    output logic [ROW_W-1:0] row_ptr
);
    localparam int unsigned CNT_W = (REF_CYC > 1) ? $clog2(REF_CYC) : 1;

    logic [CNT_W-1:0] tick_q;
    logic             wrap;

    assign wrap = (tick_q == CNT_W'(REF_CYC - 1));

    // Free-running interval counter
    always_ff @(posedge clk) begin
        if (!rst_n)    tick_q <= '0;
        else if (wrap) tick_q <= '0;
        else           tick_q <= tick_q + 1'b1;
    end

    // Pending flag: set on wrap, cleared when the sequencer starts a refresh
    always_ff @(posedge clk) begin
        if (!rst_n)    refresh_due <= 1'b0;
        else if (wrap) refresh_due <= 1'b1;
        else if (take) refresh_due <= 1'b0;
    end

    // Row pointer for row-only refresh
    always_ff @(posedge clk) begin
        if (!rst_n)       row_ptr <= '0;
        else if (adv_ptr) row_ptr <= row_ptr + 1'b1;
    end

    AST_DUE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_due && !take |=> refresh_due); // R7
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        adv_ptr |=> row_ptr == $past(row_ptr) + 1'b1); // R5

endmodule

// File: rtl/dram_strobe_seq.sv
// Strobe sequencer: runs read, write and both refresh cycles on the
// multiplexed bus. Assumes row and column halves share one width and that
// the memory drives dram_q only while both strobes are low on a read.
module dram_strobe_seq
    import dram_ctrl_pkg::*;
#(
    parameter int unsigned ROW_W = 6,
    parameter int unsigned T_RCD = 2,
    parameter int unsigned T_CAS = 1,
    parameter int unsigned T_RAS = 2,
    parameter int unsigned T_RP  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_cbr,
    input  logic               refresh_due,
    input  logic [ROW_W-1:0]   ref_row,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [2*ROW_W-1:0] req_addr,
    input  logic               req_wdata,
    input  logic               dram_q,
    output logic               take,
    output logic               adv_ptr,
    output logic               ready,
    output logic               rd_valid,
    output logic               rd_data,
    output logic [ROW_W-1:0]   dram_a,
    output logic               dram_ras_n,
    output logic               dram_cas_n,
    output logic               dram_we_n,
    output logic               dram_d
);
    localparam int unsigned ADDR_W = 2 * ROW_W;
    localparam int unsigned T_M1   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int unsigned T_M2   = (T_RAS > T_RP) ? T_RAS : T_RP;
    localparam int unsigned T_MAX  = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int unsigned CW     = $clog2(T_MAX + 1);

    seq_state_e       st_q, st_d;
    logic [CW-1:0]    wcnt_q;
    logic             wait_done;
    int unsigned      len_d;
    logic [ROW_W-1:0] row_q, col_q;
    logic             wr_q, wd_q;

    assign wait_done = (wcnt_q == '0);

    // Next-state decision; refresh wins over a host request in idle
    always_comb begin
        st_d = st_q;
        take = 1'b0;
        case (st_q)
            S_IDLE: begin
                if (refresh_due) begin
                    take = 1'b1;
                    st_d = cfg_cbr ? S_CBR_CAS : S_RF_ROW;
                end else if (req_valid) begin
                    st_d = S_ROW;
                end
            end
            S_ROW:     if (wait_done) st_d = S_RAS;
            S_RAS:     if (wait_done) st_d = S_COL;
            S_COL:     if (wait_done) st_d = S_CAS;
            S_CAS:     if (wait_done) st_d = wr_q ? S_WRUP : S_PRE;
            S_WRUP:    if (wait_done) st_d = S_PRE;
            S_PRE:     if (wait_done) st_d = S_IDLE;
            S_RF_ROW:  if (wait_done) st_d = S_RF_RAS;
            S_RF_RAS:  if (wait_done) st_d = S_PRE;
            S_CBR_CAS: if (wait_done) st_d = S_CBR_RAS;
            S_CBR_RAS: if (wait_done) st_d = S_PRE;
            default:   st_d = S_IDLE;
        endcase
    end

    // Dwell length of the state being entered
    always_comb begin
        case (st_d)
            S_RAS, S_CBR_CAS:  len_d = T_RCD;
            S_CAS:             len_d = T_CAS;
            S_RF_RAS, S_CBR_RAS: len_d = T_RAS;
            S_PRE:             len_d = T_RP;
            default:           len_d = 1;
        endcase
    end

    // State register and dwell counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            wcnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_d != st_q)   wcnt_q <= CW'(len_d - 1);
            else if (!wait_done) wcnt_q <= wcnt_q - 1'b1;
        end
    end

    // Capture the host request when it is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
            wr_q  <= 1'b0;
            wd_q  <= 1'b0;
        end else if (st_q == S_IDLE && !refresh_due && req_valid) begin
            row_q <= req_addr[ADDR_W-1:ROW_W];
            col_q <= req_addr[ROW_W-1:0];
            wr_q  <= req_write;
            wd_q  <= req_wdata;
        end
    end

    // Sample memory data at the end of the column-strobe dwell on reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 1'b0;
        end else begin
            rd_valid <= (st_q == S_CAS) && wait_done && !wr_q;
            if ((st_q == S_CAS) && wait_done && !wr_q) rd_data <= dram_q;
        end
    end

    assign adv_ptr    = (st_q == S_RF_RAS) && wait_done;
    assign ready      = (st_q == S_IDLE) && !refresh_due;
    assign dram_ras_n = !(st_q inside {S_RAS, S_COL, S_CAS, S_RF_RAS, S_CBR_RAS});
    assign dram_cas_n = !(st_q inside {S_CAS, S_WRUP, S_CBR_CAS, S_CBR_RAS});
    assign dram_we_n  = !(wr_q && (st_q inside {S_COL, S_CAS, S_WRUP}));
    assign dram_d     = wd_q;

    // Bus mux: row half, column half, or refresh pointer
    always_comb begin
        case (st_q)
            S_ROW, S_RAS:          dram_a = row_q;
            S_COL, S_CAS, S_WRUP:  dram_a = col_q;
            S_RF_ROW, S_RF_RAS:    dram_a = ref_row;
            default:               dram_a = '0;
        endcase
    end

    AST_WE_UNDER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> (!dram_ras_n || !dram_cas_n)); // R3
    AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) && !dram_cas_n |-> $past(!dram_cas_n)); // R6
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> dram_ras_n && dram_cas_n && dram_we_n); // R8
    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R2

endmodule

// File: rtl/dram_mux_ctrl.sv
// Top of the DRAM controller: derives cycle counts from the clock
// frequency and joins the refresh timer to the strobe sequencer.
// Assumes a memory of 2**ROW_W rows by 2**ROW_W columns, one bit wide.
module dram_mux_ctrl #(
    parameter int unsigned CLK_MHZ       = 10,
    parameter int unsigned ROW_W         = 6,
    parameter int unsigned REF_PERIOD_NS = 62500,
    parameter int unsigned T_RCD_NS      = 300,
    parameter int unsigned T_CAS_NS      = 200,
    parameter int unsigned T_RAS_NS      = 400,
    parameter int unsigned T_RP_NS       = 300
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_cbr,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [2*ROW_W-1:0] req_addr,
    input  logic               req_wdata,
    output logic               ready,
    output logic               rd_valid,
    output logic               rd_data,
    output logic [ROW_W-1:0]   dram_a,
    output logic               dram_ras_n,
    output logic               dram_cas_n,
    output logic               dram_we_n,
    output logic               dram_d,
    input  logic               dram_q
);
    import dram_ctrl_pkg::*;

    localparam int unsigned REF_CYC = CLK_MHZ * REF_PERIOD_NS / 1000;
    localparam int unsigned T_RCD   = ns_to_cyc(T_RCD_NS, CLK_MHZ);
    localparam int unsigned T_CAS   = ns_to_cyc(T_CAS_NS, CLK_MHZ);
    localparam int unsigned T_RAS   = ns_to_cyc(T_RAS_NS, CLK_MHZ);
    localparam int unsigned T_RP    = ns_to_cyc(T_RP_NS, CLK_MHZ);

    logic             take, adv_ptr, refresh_due;
    logic [ROW_W-1:0] ref_row;

    dram_refresh_timer #(
        .REF_CYC (REF_CYC),
        .ROW_W   (ROW_W)
    ) timer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .adv_ptr     (adv_ptr),
        .refresh_due (refresh_due),
        .row_ptr     (ref_row)
    );

    dram_strobe_seq #(
        .ROW_W (ROW_W),
        .T_RCD (T_RCD),
        .T_CAS (T_CAS),
        .T_RAS (T_RAS),
        .T_RP  (T_RP)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_cbr     (cfg_cbr),
        .refresh_due (refresh_due),
        .ref_row     (ref_row),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .dram_q      (dram_q),
        .take        (take),
        .adv_ptr     (adv_ptr),
        .ready       (ready),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .dram_a      (dram_a),
        .dram_ras_n  (dram_ras_n),
        .dram_cas_n  (dram_cas_n),
        .dram_we_n   (dram_we_n),
        .dram_d      (dram_d)
    );

endmodule

// File: tb/dram_mux_ctrl_tb_top.sv
// Scoreboard bench with a behavioural 64 x 64 DRAM model.
module dram_mux_ctrl_tb_top;
    localparam int CLK_PERIOD = 250;
    localparam int CLK_MHZ    = 4;
    localparam int REF_CYC    = CLK_MHZ * 62500 / 1000;
    localparam int SLACK      = 16;
    localparam int DEADLINE   = 64 * REF_CYC + SLACK;
    localparam int PHASE_CYC  = 36000;

    logic clk = 1'b0, rst_n = 1'b0, cfg_cbr = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
    logic [11:0] req_addr = '0;
    logic ready, rd_valid, rd_data, ras_n, cas_n, we_n, dram_d;
    logic [5:0] dram_a;
    wire dram_q;

    int errs = 0, checks = 0, cyc = 0;
    bit done = 1'b0;

    dram_mux_ctrl #(.CLK_MHZ(CLK_MHZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_cbr(cfg_cbr), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data), .dram_a(dram_a),
        .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
        .dram_d(dram_d), .dram_q(dram_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [63:0] mem_a [64];
    logic [63:0] m_buf;
    logic [5:0]  m_row, m_col;
    logic        m_cas_seen = 1'b0, m_cbr = 1'b0, m_wr = 1'b0;
    int          m_iptr = 0;
    int          last_ref [64];
    int          exp_ptr = 0, n_ref = 0, prev_ref = -1, ph_start = 0;
    bit          cur_cbr = 1'b0;

    assign dram_q = (!ras_n && !cas_n && m_cas_seen && we_n) ? m_buf[m_col] : 1'bz;

    task automatic note_refresh(int row);
        chk(cyc - last_ref[row] <= DEADLINE, "R7", "row refresh gap", cyc - last_ref[row], DEADLINE);
        last_ref[row] = cyc;
    endtask

    always @(negedge ras_n) begin
        m_cas_seen = 1'b0;
        m_wr = 1'b0;
        if (!cas_n) begin
            m_cbr = 1'b1;
            chk(we_n == 1'b1, "R6", "we_n at column-first refresh", int'(we_n), 1);
        end else begin
            m_cbr = 1'b0;
            m_row = dram_a;
            m_buf = mem_a[dram_a];
        end
    end

    always @(negedge cas_n) begin
        if (!ras_n) begin
            m_col = dram_a;
            m_cas_seen = 1'b1;
            m_wr = !we_n;
            if (!we_n) m_buf[dram_a] = dram_d;
        end
    end

    always @(posedge cas_n) begin
        if (m_wr && m_cas_seen)
            chk(ras_n == 1'b1, "R3", "row strobe up before column strobe", int'(ras_n), 1);
    end

    always @(posedge ras_n) begin
        if (rst_n) begin
            if (m_cbr) begin
                chk(cur_cbr == 1'b1, "R10", "column-first refresh style", 1, int'(cur_cbr));
                chk(ready == 1'b0, "R8", "ready during refresh", int'(ready), 0);
                note_refresh(m_iptr);
                m_iptr = (m_iptr + 1) % 64;
            end else if (!m_cas_seen) begin
                chk(cur_cbr == 1'b0, "R10", "row-only refresh style", 0, int'(cur_cbr));
                chk(ready == 1'b0, "R8", "ready during refresh", int'(ready), 0);
                chk(int'(m_row) == exp_ptr, "R5", "refresh row pointer", int'(m_row), exp_ptr);
                exp_ptr = (exp_ptr + 1) % 64;
                mem_a[m_row] = m_buf;
                note_refresh(int'(m_row));
            end else begin
                if (m_wr) chk(cas_n == 1'b0, "R3", "column strobe low at write-back", int'(cas_n), 0);
                mem_a[m_row] = m_buf;
                last_ref[m_row] = cyc;
            end
            if (m_cbr || !m_cas_seen) begin
                n_ref++;
                if (prev_ref >= 0)
                    chk((cyc - prev_ref >= REF_CYC - 9) && (cyc - prev_ref <= REF_CYC + 9),
                        "R4", "refresh spacing", cyc - prev_ref, REF_CYC);
                prev_ref = cyc;
            end
        end
    end

    // ---------------- scoreboard ----------------
    logic [63:0] shad [64];
    bit          exp_q[$];
    int          addr_q[$];

    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected read data", 1, 0);
            end else begin
                bit e;
                int a;
                e = exp_q.pop_front();
                a = addr_q.pop_front();
                chk(rd_data == e, "R1", $sformatf("read data at 0x%03h", a), int'(rd_data), int'(e));
            end
        end
    end

    task automatic issue(bit wr, logic [11:0] a, bit d);
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (wr) begin
            shad[a[11:6]][a[5:0]] = d;
        end else begin
            exp_q.push_back(shad[a[11:6]][a[5:0]]);
            addr_q.push_back(int'(a));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(ras_n && cas_n && we_n, "R9", "strobes high in reset", int'({ras_n, cas_n, we_n}), 7);
        rst_n = 1'b1;
        exp_ptr = 0; n_ref = 0; prev_ref = -1; ph_start = cyc;
        for (int r = 0; r < 64; r++) last_ref[r] = cyc;
        @(negedge clk);
        chk(ready == 1'b1, "R9", "ready after reset", int'(ready), 1);
        chk(rd_valid == 1'b0, "R9", "rd_valid after reset", int'(rd_valid), 0);
        chk(ras_n && cas_n && we_n, "R9", "strobes high after reset", int'({ras_n, cas_n, we_n}), 7);
    endtask

    task automatic run_phase(int seed);
        int unsigned x;
        int          pend;
        x = 32'h1234_5678 ^ seed;
        // corners and walking patterns
        issue(1, 12'h000, 1); issue(1, 12'hFFF, 1); issue(1, 12'h03F, 1); issue(1, 12'hFC0, 1);
        issue(0, 12'h000, 0); issue(0, 12'hFFF, 0); issue(0, 12'h03F, 0); issue(0, 12'hFC0, 0);
        issue(0, 12'h001, 0); issue(0, 12'h040, 0);
        for (int i = 0; i < 12; i++) issue(1, 12'(1 << i), i[0]);
        for (int i = 0; i < 12; i++) issue(0, 12'(1 << i), 0);
        // idle stretch: refresh alone, then check retention
        repeat (1500) @(negedge clk);
        issue(0, 12'hFFF, 0); issue(0, 12'h000, 0);
        // mixed traffic until the phase length has passed
        while (cyc - ph_start < PHASE_CYC) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            issue(x[12], x[11:0], x[13]);
        end
        pend = 0;
        while (exp_q.size() != 0 && pend < 100) begin @(negedge clk); pend++; end
        chk(exp_q.size() == 0, "R2", "reads left outstanding", exp_q.size(), 0);
        for (int r = 0; r < 64; r++)
            chk(cyc - last_ref[r] <= DEADLINE, "R7", $sformatf("row %0d age at phase end", r),
                cyc - last_ref[r], DEADLINE);
        chk((n_ref >= (cyc - ph_start) / REF_CYC - 1) && (n_ref <= (cyc - ph_start) / REF_CYC + 1),
            "R4", "refresh count in phase", n_ref, (cyc - ph_start) / REF_CYC);
    endtask

    initial begin
        for (int r = 0; r < 64; r++) begin mem_a[r] = '0; shad[r] = '0; last_ref[r] = 0; end
        cur_cbr = 1'b0; cfg_cbr = 1'b0;
        do_reset();
        run_phase(1);               // R5 row-only refresh
        @(negedge clk);
        while (!ready) @(negedge clk);
        cur_cbr = 1'b1; cfg_cbr = 1'b1;
        do_reset();
        run_phase(2);               // R6 column-first refresh
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule